// File: doc/BRIEF.md
# PCI Bus Initiator Sequencer

This block runs one internal request as a PCI master transaction. A request carries an address, a 4-bit PCI command code, byte enables and a burst length of 1 to 8 data phases. The block then requests the bus and waits for grant. It drives one address phase and then the data phases. It finishes with a single turnaround cycle and a completion pulse that reports an error flag and the number of phases left undone.

The request port is a valid/ready handshake. A request is taken in a cycle where both `req_valid` and `req_ready` are high. Write beats use their own valid/ready pair, and the block holds `wr_ready` low whenever it cannot take a beat. The block buffers the whole write burst before it asks for the bus, because PCI data phases must run without master wait states. Read data returns on `rd_valid`/`rd_data` with no back-pressure, since a PCI master that inserts no wait states cannot stall. The sink must accept one word in any cycle.

The bus side uses separate output-enable and input buses in place of tri-states. All PCI control pins are active low.

Top module: `pci_init_seq`

## Requirements
- R1: For a write command, `pci_req_n` stays high while write beats are still being taken. It goes low in the cycle after the final beat is accepted. `wr_ready` is never high while `pci_req_n` is low.
- R2: For a read command, `pci_req_n` goes low in the cycle right after the request is accepted.
- R3: The address phase occurs in the cycle after `pci_gnt_n` is sampled low while requesting. In that cycle `pci_frame_n` is 0 and `pci_irdy_n` is 1. `pci_ad_out` carries the request address and `pci_cbe_out` carries the command code, both enabled. From that cycle on, `pci_req_n` is high.
- R4: From the first data phase to the last, `pci_irdy_n` stays low every cycle, so no master wait state occurs. During data phases `pci_cbe_out` carries the byte enables. For writes, `pci_ad_out` carries beat k during phase k.
- R5: A data phase completes only at an edge where `pci_irdy_n` and `pci_trdy_n` are both low. Read words appear on `rd_valid`/`rd_data` one cycle after their phase completes, in order.
- R6: `pci_frame_n` is high during the final data phase, while `pci_irdy_n` is low.
- R7: After the final phase completes, one turnaround cycle follows. In it `pci_frame_n` and `pci_irdy_n` are high, both output enables are low, and `done_valid` pulses with `done_err`=0 and `done_left`=0.
- R8: If `pci_devsel_n` is still high at all of the five edges that follow the address phase, the transaction ends as a master abort. The pulse then reports `done_err`=1 and `done_left` equal to the request length.
- R9: When `pci_stop_n` is sampled low, the burst ends after the current phase. `done_left` equals the length minus the phases completed.
- R10: Whenever the transaction ends early (R8 or R9) and `pci_frame_n` is still low, one cycle with `pci_frame_n` high and `pci_irdy_n` low follows. Then comes the turnaround cycle.
- R11: Command bit 0 selects the direction: 1 is a write and 0 is a read. The codes are 0000 interrupt acknowledge, 0001 special cycle, 0010/0011 I/O, 0110/0111 memory and 1010/1011 configuration. The block drives AD in data phases only for writes.
- R12: A special cycle (0001) that times out under the R8 rule reports `done_err`=0 and `done_left`=0.
- R13: After reset, `pci_req_n`, `pci_frame_n` and `pci_irdy_n` are high, the output enables are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | 32 | Transaction address |
| req_cmd | input | 4 | PCI command code |
| req_be | input | 4 | Byte enables for every data phase, active low |
| req_len | input | 4 | Number of data phases, 1 to 8 |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat taken |
| wr_data | input | 32 | Write beat |
| rd_valid | output | 1 | Read word valid, no back-pressure |
| rd_data | output | 32 | Read word |
| done_valid | output | 1 | Completion pulse |
| done_err | output | 1 | Master abort flag |
| done_left | output | 4 | Data phases not completed |
| pci_req_n | output | 1 | Bus request |
| pci_gnt_n | input | 1 | Bus grant |
| pci_frame_n | output | 1 | Frame |
| pci_irdy_n | output | 1 | Initiator ready |
| pci_trdy_n | input | 1 | Target ready |
| pci_devsel_n | input | 1 | Device select |
| pci_stop_n | input | 1 | Target stop |
| pci_ad_out | output | 32 | Address/data driven |
| pci_ad_oe | output | 1 | Address/data enable |
| pci_ad_in | input | 32 | Address/data received |
| pci_cbe_out | output | 4 | Command / byte enables driven |
| pci_cbe_oe | output | 1 | Command / byte enable enable |

## Verification
The assertions check on every cycle the properties that depend only on the pins themselves. These are the write-buffering and read-request timing, the address phase that follows grant, an IRDY# that never lifts while FRAME# is low, and the release of all drivers after the last handshake. The bench's scenarios are needed for the rest, because those behaviours depend on what the target did several cycles earlier. This covers the five-clock DEVSEL# window and its master abort, the special-cycle exemption, the remaining count after STOP#, the extra frame-release cycle, and the values and order of the data words.

// File: rtl/pci_init_pkg.sv
package pci_init_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FILL, S_REQ, S_ADDR, S_DATA, S_ABRT, S_TURN
  } seq_state_t;

  localparam logic [3:0] CMD_SPECIAL = 4'b0001;
endpackage

// File: rtl/pci_wr_buf.sv
module pci_wr_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic [DATA_W-1:0] push_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk)
      if (push && push_idx == IDX_W'(i)) slot[i] <= push_data;
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/pci_devsel_timer.sv
module pci_devsel_timer #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic devsel_n,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (active) begin
      if (!devsel_n) seen <= 1'b1;
      else if (!seen) cnt <= cnt + 1'b1;
    end
  end

  assign expired = active && !seen && devsel_n && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/pci_init_seq.sv
module pci_init_seq
  import pci_init_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MAX_BEATS  = 8,
  parameter int ABORT_CLKS = 5,
  parameter int LEN_W      = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [3:0]        req_cmd,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done_valid,
  output logic              done_err,
  output logic [LEN_W-1:0]  done_left,
  output logic              pci_req_n,
  input  logic              pci_gnt_n,
  output logic              pci_frame_n,
  output logic              pci_irdy_n,
  input  logic              pci_trdy_n,
  input  logic              pci_devsel_n,
  input  logic              pci_stop_n,
  output logic [DATA_W-1:0] pci_ad_out,
  output logic              pci_ad_oe,
  input  logic [DATA_W-1:0] pci_ad_in,
  output logic [DATA_W/8-1:0] pci_cbe_out,
  output logic              pci_cbe_oe
);
  localparam int IDX_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam int BE_W  = DATA_W / 8;

  seq_state_t          st;
  logic [DATA_W-1:0]   addr_q;
  logic [3:0]          cmd_q;
  logic [BE_W-1:0]     be_q;
  logic [LEN_W-1:0]    len_q, left_q, fill_q;
  logic [IDX_W-1:0]    idx_q;
  logic                err_q;
  logic [DATA_W-1:0]   buf_word;
  logic                is_wr, special, last, xfer, stop_hit, expired, push;

  assign is_wr    = cmd_q[0];
  assign special  = (cmd_q == CMD_SPECIAL);
  assign last     = (left_q == LEN_W'(1));
  assign xfer     = (st == S_DATA) && !pci_trdy_n;
  assign stop_hit = (st == S_DATA) && !pci_stop_n;
  assign push     = (st == S_FILL) && wr_valid;

  pci_wr_buf #(.DATA_W(DATA_W), .DEPTH(MAX_BEATS), .IDX_W(IDX_W)) u_buf (
    .clk      (clk),
    .push     (push),
    .push_idx (fill_q[IDX_W-1:0]),
    .push_data(wr_data),
    .rd_idx   (idx_q),
    .rd_data  (buf_word)
  );

  pci_devsel_timer #(.LIMIT(ABORT_CLKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (st == S_ADDR),
    .active  (st == S_DATA),
    .devsel_n(pci_devsel_n),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      cmd_q    <= '0;
      be_q     <= '0;
      len_q    <= '0;
      left_q   <= '0;
      fill_q   <= '0;
      idx_q    <= '0;
      err_q    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          cmd_q  <= req_cmd;
          be_q   <= req_be;
          len_q  <= req_len;
          left_q <= req_len;
          fill_q <= '0;
          idx_q  <= '0;
          err_q  <= 1'b0;
          st     <= req_cmd[0] ? S_FILL : S_REQ;
        end
        S_FILL: if (push) begin
          fill_q <= fill_q + 1'b1;
          if (fill_q == len_q - 1'b1) st <= S_REQ;
        end
        S_REQ:  if (!pci_gnt_n) st <= S_ADDR;
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          if (xfer) begin
            left_q <= left_q - 1'b1;
            idx_q  <= idx_q + 1'b1;
            if (!is_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= pci_ad_in;
            end
            if (last)          st <= S_TURN;
            else if (stop_hit) st <= S_ABRT;
          end else if (stop_hit) begin
            st <= last ? S_TURN : S_ABRT;
          end else if (expired) begin
            err_q <= !special;
            if (special) left_q <= '0;
            st <= last ? S_TURN : S_ABRT;
          end
        end
        S_ABRT: st <= S_TURN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign wr_ready    = (st == S_FILL);
  assign pci_req_n   = (st != S_REQ);
  assign pci_frame_n = !((st == S_ADDR) || ((st == S_DATA) && !last));
  assign pci_irdy_n  = !((st == S_DATA) || (st == S_ABRT));
  assign pci_ad_oe   = (st == S_ADDR) || (((st == S_DATA) || (st == S_ABRT)) && is_wr);
  assign pci_ad_out  = (st == S_ADDR) ? addr_q : buf_word;
  assign pci_cbe_oe  = (st == S_ADDR) || (st == S_DATA) || (st == S_ABRT);
  assign pci_cbe_out = (st == S_ADDR) ? cmd_q[BE_W-1:0] : be_q;
  assign done_valid  = (st == S_TURN);
  assign done_err    = err_q;
  assign done_left   = left_q;
endmodule

// File: rtl/pci_init_chk.sv
module pci_init_chk #(
  parameter int MAX_BEATS = 8,
  parameter int LEN_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [3:0]       req_cmd,
  input logic             wr_ready,
  input logic             done_valid,
  input logic [LEN_W-1:0] done_left,
  input logic             pci_req_n,
  input logic             pci_gnt_n,
  input logic             pci_frame_n,
  input logic             pci_irdy_n,
  input logic             pci_trdy_n,
  input logic             pci_ad_oe,
  input logic             pci_cbe_oe
);
  AST_WR_HELD_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_req_n |-> !wr_ready); // R1

  AST_READ_REQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_cmd[0] |=> !pci_req_n); // R2

  AST_ADDR_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_req_n && !pci_gnt_n |=> !pci_frame_n && pci_irdy_n && pci_ad_oe && pci_cbe_oe && pci_req_n); // R3

  AST_NO_MASTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_irdy_n && !pci_frame_n |=> !pci_irdy_n); // R4

  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pci_frame_n && !pci_irdy_n && !pci_trdy_n |=> pci_irdy_n && pci_frame_n && !pci_ad_oe && !pci_cbe_oe && done_valid); // R7

  AST_DONE_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_left <= LEN_W'(MAX_BEATS) && pci_irdy_n); // R9
endmodule

bind pci_init_seq pci_init_chk #(.MAX_BEATS(MAX_BEATS), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cmd(req_cmd), .wr_ready(wr_ready), .done_valid(done_valid),
  .done_left(done_left), .pci_req_n(pci_req_n), .pci_gnt_n(pci_gnt_n),
  .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n), .pci_trdy_n(pci_trdy_n),
  .pci_ad_oe(pci_ad_oe), .pci_cbe_oe(pci_cbe_oe)
);

// File: tb/sim_pci_init_seq.sv
module sim_pci_init_seq;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0] req_cmd = '0, req_be = '0, req_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [31:0] wr_data = '0;
  logic rd_valid; logic [31:0] rd_data;
  logic done_valid, done_err; logic [3:0] done_left;
  logic pci_req_n, pci_gnt_n = 1'b1, pci_frame_n, pci_irdy_n;
  logic pci_trdy_n = 1'b1, pci_devsel_n = 1'b1, pci_stop_n = 1'b1;
  logic [31:0] pci_ad_out, pci_ad_in = '0;
  logic pci_ad_oe, pci_cbe_oe; logic [3:0] pci_cbe_out;

  always #(CLK_P/2) clk = ~clk;

  pci_init_seq u0 (.*);

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scenario
  int sc_len, sc_dly, sc_stop, sc_id;
  logic [3:0] sc_cmd, sc_be; logic [31:0] sc_addr;
  logic [31:0] wbeat [8];
  logic [1:0] expq [$];
  logic [31:0] rdq [$];
  bit active = 0, done_seen = 0, got_err; int got_left;
  int tc, tn; bit tstop;

  function automatic logic [31:0] rd_pat(int k);
    return 32'h5A00_0000 + (sc_id << 8) + k;
  endfunction

  task automatic build_expect();
    int n = 0, c = 0; bit fin = 0; bit fr;
    expq.delete();
    while (!fin) begin
      fr = (sc_len - n == 1);
      expq.push_back({fr, 1'b0});
      if (c >= sc_dly) begin
        n++;
        if (n == sc_len) fin = 1;
        else if (n == sc_stop) begin expq.push_back(2'b10); fin = 1; end
      end else if (c == 4) begin
        if (!fr) expq.push_back(2'b10);
        fin = 1;
      end
      c++;
    end
    expq.push_back(2'b11);
  endtask

  // target model and per-cycle comparison
  always @(negedge clk) begin
    logic [1:0] e;
    if (rd_valid) rdq.push_back(rd_data);
    if (done_valid) begin done_seen = 1; got_err = done_err; got_left = done_left; end
    if (active && expq.size() > 0) begin
      e = expq.pop_front();
      check({pci_frame_n, pci_irdy_n} == e, "R6 R10 frame/irdy sequence", {pci_frame_n, pci_irdy_n}, e);
      if (e == 2'b11)
        check(!pci_ad_oe && !pci_cbe_oe, "R7 turnaround releases drivers", {pci_ad_oe, pci_cbe_oe}, 0);
    end
    if (active && !pci_frame_n && pci_irdy_n) begin
      check(pci_ad_out == sc_addr && pci_ad_oe, "R3 address on AD", pci_ad_out, sc_addr);
      check(pci_cbe_out == sc_cmd, "R11 command on C/BE", pci_cbe_out, sc_cmd);
      build_expect();
      tc = 0; tn = 0; tstop = 0;
      {pci_devsel_n, pci_trdy_n, pci_stop_n} = 3'b111;
    end else if (active && !pci_irdy_n) begin
      if (tstop) {pci_devsel_n, pci_trdy_n, pci_stop_n} = 3'b010;
      else if (tc >= sc_dly) begin
        check(pci_cbe_out == sc_be, "R4 byte enables in data phase", pci_cbe_out, sc_be);
        check(pci_ad_oe == sc_cmd[0], "R11 AD driven only for writes", pci_ad_oe, sc_cmd[0]);
        if (sc_cmd[0]) check(pci_ad_out == wbeat[tn], "R4 write beat order", pci_ad_out, wbeat[tn]);
        pci_ad_in = rd_pat(tn);
        pci_devsel_n = 1'b0; pci_trdy_n = 1'b0;
        if (tn + 1 == sc_stop) begin pci_stop_n = 1'b0; tstop = 1; end
        tn++;
      end else {pci_devsel_n, pci_trdy_n, pci_stop_n} = 3'b111;
      tc++;
    end else {pci_devsel_n, pci_trdy_n, pci_stop_n} = 3'b111;
  end

  task automatic run(input int id, input logic [3:0] cmd, input logic [31:0] addr, input logic [3:0] be,
                     input int len, input int dly, input int stp, input int gdel);
    int ndone, exp_left, t; bit exp_err, special, abort;
    sc_id = id; sc_cmd = cmd; sc_addr = addr; sc_be = be; sc_len = len; sc_dly = dly; sc_stop = stp;
    for (int k = 0; k < 8; k++) wbeat[k] = 32'hD000_0000 + (id << 8) + k;
    rdq.delete(); done_seen = 0; active = 1;
    special = (cmd == 4'b0001);
    abort = (dly >= 5);
    ndone = abort ? 0 : ((stp > 0 && stp < len) ? stp : len);
    exp_left = abort ? (special ? 0 : len) : len - ndone;
    exp_err = abort && !special;
    @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_addr = addr; req_be = be; req_len = 4'(len);
    @(negedge clk);
    req_valid = 0;
    if (!cmd[0]) check(pci_req_n == 0, "R2 read requests at once", pci_req_n, 0);
    else begin
      for (int k = 0; k < len; k++) begin
        check(pci_req_n == 1, "R1 no request while filling", pci_req_n, 1);
        @(negedge clk);
        wr_valid = 1; wr_data = wbeat[k];
        @(negedge clk);
        wr_valid = 0;
      end
      check(pci_req_n == 0, "R1 request after last beat", pci_req_n, 0);
    end
    for (int k = 0; k < gdel; k++) @(negedge clk);
    check(pci_req_n == 0, "R3 request held until grant", pci_req_n, 0);
    pci_gnt_n = 0;
    @(negedge clk);
    check(pci_frame_n == 0 && pci_req_n == 1, "R3 address phase after grant", {pci_frame_n, pci_req_n}, 2'b01);
    pci_gnt_n = 1;
    t = 0;
    while (!done_seen && t < 100) begin @(negedge clk); t++; end
    check(done_seen, "R7 completion pulse", done_seen, 1);
    check(got_err == exp_err, abort ? (special ? "R12 special no error" : "R8 abort error") : "R7 no error", got_err, exp_err);
    check(got_left == exp_left, abort ? "R8 R12 left count" : "R9 left count", got_left, exp_left);
    check(expq.size() == 0, "R10 whole sequence seen", expq.size(), 0);
    if (!cmd[0]) begin
      check(rdq.size() == ndone, "R5 read word count", rdq.size(), ndone);
      for (int k = 0; k < rdq.size(); k++)
        check(rdq[k] == rd_pat(k), "R5 read word value", rdq[k], rd_pat(k));
    end
    active = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pci_req_n && pci_frame_n && pci_irdy_n && !pci_ad_oe && !pci_cbe_oe && req_ready,
          "R13 reset state", {pci_req_n, pci_frame_n, pci_irdy_n, pci_ad_oe, pci_cbe_oe, req_ready}, 6'b111001);
    rst_n = 1;
    @(negedge clk);
    run(1, 4'b0111, 32'h8000_0010, 4'b0000, 4, 0, 0, 2);   // memory write burst
    run(2, 4'b0110, 32'h8000_1000, 4'b0000, 8, 2, 0, 0);   // memory read, slow DEVSEL#
    run(3, 4'b0011, 32'h0000_0CF8, 4'b1100, 1, 1, 0, 1);   // I/O write
    run(4, 4'b1010, 32'h0000_0040, 4'b0000, 1, 4, 0, 0);   // configuration read, last DEVSEL# edge
    run(5, 4'b0110, 32'h9000_0000, 4'b0000, 3, 99, 0, 0);  // R8 master abort
    run(6, 4'b0111, 32'h8000_2000, 4'b0011, 6, 0, 2, 1);   // R9 stop after two phases
    run(7, 4'b0001, 32'h0000_0000, 4'b0000, 1, 99, 0, 0);  // R12 special cycle
    run(8, 4'b0000, 32'h0000_0000, 4'b1110, 1, 0, 0, 3);   // interrupt acknowledge
    run(9, 4'b0110, 32'h8000_3000, 4'b0000, 8, 0, 8, 0);   // stop on final phase
    run(10, 4'b1011, 32'h0000_0080, 4'b0000, 2, 1, 0, 0);  // configuration write
    run(11, 4'b0111, 32'hA000_0000, 4'b0000, 1, 99, 0, 0); // abort with frame already high
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule